// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block sits beside a small CPU's control unit. It takes eight maskable interrupt request lines and picks the most urgent one. Line 0 is the most urgent and line 7 the least. A single global mask stops the control unit from being told about requests, but the chosen level is still visible on the outputs while masked.

When the control unit acknowledges an interrupt, the block does two things. It writes the accepted level into a three-bit field of a secondary flags register. It also latches the vector address the CPU should fetch next. A mode input chooses between two vector schemes:

- **Shared mode:** every request, and BRK, uses one common vector.
- **Per-level mode:** each request level has its own vector word. These words sit in a row just below the common vector.

The flags register has a read port and a write port so that transfer instructions can move it to and from the accumulator. It changes only through those writes and on acceptance.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `sr_rd_data` is 8'h00, `vec_addr` is 16'hFFFE and `irq_signal` is 0.
- R2: `req_valid` is 1 when any `irq_req` bit is set. `req_level` is then the index of the lowest-numbered set bit, so bit 0 wins over every other bit.
- R3: `irq_signal` equals `req_valid` while `irq_mask` is 0, and is 0 while `irq_mask` is 1. `req_valid` and `req_level` keep following `irq_req` while masked.
- R4: A request is accepted at a rising clock edge where `irq_ack` and `irq_signal` are both 1. From that edge onward, `sr_rd_data` bits [3:1] hold the `req_level` seen at that edge. Bits 0 and [7:4] are left unchanged.
- R5: An `irq_ack` at an edge where `irq_signal` is 0 changes neither `sr_rd_data` nor `vec_addr`.
- R6: When a request is accepted with `vec_split` at 0, `vec_addr` becomes the shared vector 16'hFFFE.
- R7: When a request is accepted with `vec_split` at 1, `vec_addr` becomes 16'hFFEE + 2*level. Level 0 is at 16'hFFEE and level 7 at 16'hFFFC.
- R8: A `brk_ack` at an edge with no acceptance sets `vec_addr` to 16'hFFFE in either mode and leaves `sr_rd_data` bits [3:1] unchanged. When a request is accepted at the same edge, the acceptance decides `vec_addr`.
- R9: A `sr_wr_en` at an edge loads `sr_wr_data` into the flags register, and the new value shows on `sr_rd_data` after that edge.
- R10: When a write and an acceptance happen at the same edge, bits [3:1] take the accepted level and all other bits take `sr_wr_data`.
- R11: At an edge with neither a write nor an acceptance, `sr_rd_data` keeps its value, whatever the request, mask and BRK inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 8 | Request lines; bit 0 is the most urgent |
| irq_mask | input | 1 | Global mask; 1 blocks signalling to the control unit |
| irq_ack | input | 1 | Acknowledge strobe from the control unit |
| brk_ack | input | 1 | A BRK is being taken this cycle |
| vec_split | input | 1 | Vector mode: 0 shared, 1 one vector per level |
| sr_wr_en | input | 1 | Transfer-instruction write to the flags register |
| sr_wr_data | input | 8 | Data for that write |
| sr_rd_data | output | 8 | Flags register contents; bits [3:1] hold the last accepted level |
| irq_signal | output | 1 | Unmasked request pending, to the control unit |
| req_valid | output | 1 | Some request is pending, masked or not |
| req_level | output | 3 | Level of the most urgent pending request |
| vec_addr | output | 16 | Latched vector address for the last accepted event |

## Verification
Several behaviours are checked by assertions on every cycle:
- the priority choice and its masking;
- the capture of the level one cycle after acceptance;
- the vector produced in each mode and for BRK;
- the flags register holding its value when neither a write nor an acceptance occurs.

Some behaviours only the bench's scenarios can show:
- that each row of the priority table yields the exact vector word;
- that a write and an acceptance in the same cycle merge their bits correctly;
- that bits outside the level field survive a series of acceptances;
- that BRK in per-level mode still returns the shared word.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    parameter int NUM_LVL  = 8;
    parameter int LVL_W    = $clog2(NUM_LVL);
    parameter int SR_W     = 8;
    parameter int LVL_LSB  = 1;
    parameter int ADDR_W   = 16;
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFFE;

    // Registered state of the controller
    typedef struct packed {
        logic [SR_W-1:0]   sr;
        logic [ADDR_W-1:0] vec;
    } ctl_state_t;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         valid,
    output logic [W-1:0] lvl
);
    always_comb begin
        valid = |req;
        lvl   = '0;
        // Scan downward so the lowest set index is the last one written
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) lvl = W'(i);
        end
    end
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
    parameter int N = 8,
    parameter int W = $clog2(N),
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'hFFFE
) (
    input  logic              split,
    input  logic [W-1:0]      lvl,
    output logic [ADDR_W-1:0] vec
);
    localparam logic [ADDR_W-1:0] SPAN   = ADDR_W'(2 * N);
    localparam logic [ADDR_W-1:0] ROW_LO = BASE - SPAN;

    logic [ADDR_W-1:0] per_lvl;

    always_comb begin
        per_lvl = ROW_LO + {{(ADDR_W-W-1){1'b0}}, lvl, 1'b0};
        vec     = split ? per_lvl : BASE;
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_LVL-1:0] irq_req,
    input  logic              irq_mask,
    input  logic              irq_ack,
    input  logic              brk_ack,
    input  logic              vec_split,
    input  logic              sr_wr_en,
    input  logic [SR_W-1:0]   sr_wr_data,
    output logic [SR_W-1:0]   sr_rd_data,
    output logic              irq_signal,
    output logic              req_valid,
    output logic [LVL_W-1:0]  req_level,
    output logic [ADDR_W-1:0] vec_addr
);
    ctl_state_t st_d, st_q;
    logic [ADDR_W-1:0] cand_vec;
    logic take;

    irq_prio_enc #(.N(NUM_LVL), .W(LVL_W)) u_enc (
        .req   (irq_req),
        .valid (req_valid),
        .lvl   (req_level)
    );

    irq_vec_gen #(.N(NUM_LVL), .W(LVL_W), .ADDR_W(ADDR_W), .BASE(VEC_BASE)) u_vec (
        .split (vec_split),
        .lvl   (req_level),
        .vec   (cand_vec)
    );

    always_comb begin
        irq_signal = req_valid & ~irq_mask;
        take       = irq_ack & irq_signal;
        st_d       = st_q;
        if (sr_wr_en) st_d.sr = sr_wr_data;
        if (take) begin
            // Acceptance overlays only the level field
            st_d.sr[LVL_LSB +: LVL_W] = req_level;
            st_d.vec                  = cand_vec;
        end else if (brk_ack) begin
            st_d.vec = VEC_BASE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sr  <= '0;
            st_q.vec <= VEC_BASE;
        end else begin
            st_q <= st_d;
        end
    end

    assign sr_rd_data = st_q.sr;
    assign vec_addr   = st_q.vec;
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk
    import prio_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_LVL-1:0] irq_req,
    input logic              irq_mask,
    input logic              irq_ack,
    input logic              brk_ack,
    input logic              vec_split,
    input logic              sr_wr_en,
    input logic [SR_W-1:0]   sr_rd_data,
    input logic              irq_signal,
    input logic              req_valid,
    input logic [LVL_W-1:0]  req_level,
    input logic [ADDR_W-1:0] vec_addr
);
    localparam logic [ADDR_W-1:0] ROW_LO = VEC_BASE - ADDR_W'(2 * NUM_LVL);

    logic took;
    logic [NUM_LVL-1:0] below;
    assign took  = irq_ack & irq_signal;
    assign below = (NUM_LVL'(1) << req_level) - NUM_LVL'(1);

    a_r2_level_set: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> irq_req[req_level]);
    a_r2_none_higher: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((irq_req & below) == '0));
    a_r3_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq_signal);
    a_r3_still_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask && (irq_req != '0)) |-> req_valid);
    a_r4_level_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> sr_rd_data[LVL_LSB +: LVL_W] == $past(req_level));
    a_r5_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq_signal && !brk_ack && !sr_wr_en) |=> ($stable(vec_addr) && $stable(sr_rd_data)));
    a_r6_shared_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (took && !vec_split) |=> vec_addr == VEC_BASE);
    a_r7_split_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (took && vec_split) |=> vec_addr == ROW_LO + ADDR_W'({$past(req_level), 1'b0}));
    a_r8_brk_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_ack && !took) |=> vec_addr == VEC_BASE);
    a_r11_sr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sr_wr_en && !took) |=> $stable(sr_rd_data));
endmodule

bind prio_irq_ctrl prio_irq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .irq_mask   (irq_mask),
    .irq_ack    (irq_ack),
    .brk_ack    (brk_ack),
    .vec_split  (vec_split),
    .sr_wr_en   (sr_wr_en),
    .sr_rd_data (sr_rd_data),
    .irq_signal (irq_signal),
    .req_valid  (req_valid),
    .req_level  (req_level),
    .vec_addr   (vec_addr)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_req = '0;
    logic        irq_mask = 1'b0;
    logic        irq_ack = 1'b0;
    logic        brk_ack = 1'b0;
    logic        vec_split = 1'b0;
    logic        sr_wr_en = 1'b0;
    logic [7:0]  sr_wr_data = '0;
    logic [7:0]  sr_rd_data;
    logic        irq_signal;
    logic        req_valid;
    logic [2:0]  req_level;
    logic [15:0] vec_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    prio_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_mask(irq_mask),
        .irq_ack(irq_ack), .brk_ack(brk_ack), .vec_split(vec_split),
        .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .sr_rd_data(sr_rd_data),
        .irq_signal(irq_signal), .req_valid(req_valid), .req_level(req_level),
        .vec_addr(vec_addr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] vexp(input logic split, input logic [2:0] lvl);
        return split ? (16'hFFEE + 16'(lvl) * 16'd2) : 16'hFFFE;
    endfunction

    // Row layout: req[14:7] mask[6] split[5] sig[4] lvl[3:1] valid[0]
    localparam logic [14:0] TBL [10] = '{
        {8'h01, 1'b0, 1'b0, 1'b1, 3'd0, 1'b1},
        {8'h80, 1'b0, 1'b1, 1'b1, 3'd7, 1'b1},
        {8'hA4, 1'b0, 1'b1, 1'b1, 3'd2, 1'b1},
        {8'hF0, 1'b0, 1'b0, 1'b1, 3'd4, 1'b1},
        {8'h18, 1'b0, 1'b1, 1'b1, 3'd3, 1'b1},
        {8'h02, 1'b0, 1'b1, 1'b1, 3'd1, 1'b1},
        {8'h40, 1'b0, 1'b1, 1'b1, 3'd6, 1'b1},
        {8'hFF, 1'b0, 1'b1, 1'b1, 3'd0, 1'b1},
        {8'h20, 1'b1, 1'b1, 1'b0, 3'd5, 1'b1},
        {8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0}
    };

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  exp_sr;
        logic [15:0] exp_vec;

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 sr", 32'(sr_rd_data), 32'h00);
        check("R1 vec", 32'(vec_addr), 32'hFFFE);
        check("R1 signal", 32'(irq_signal), 32'h0);
        rst_n = 1'b1;
        exp_sr = 8'h00;
        exp_vec = 16'hFFFE;

        // Table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            irq_req   = TBL[i][14:7];
            irq_mask  = TBL[i][6];
            vec_split = TBL[i][5];
            #1;
            check("R2 valid", 32'(req_valid), 32'(TBL[i][0]));
            if (TBL[i][0]) check("R2 level", 32'(req_level), 32'(TBL[i][3:1]));
            check("R3 signal", 32'(irq_signal), 32'(TBL[i][4]));
            irq_ack = 1'b1;
            @(negedge clk);
            irq_ack = 1'b0;
            if (TBL[i][4]) begin
                exp_sr  = {4'b0, TBL[i][3:1], 1'b0};
                exp_vec = vexp(TBL[i][5], TBL[i][3:1]);
            end
            check(TBL[i][4] ? "R4 sr level" : "R5 sr kept", 32'(sr_rd_data), 32'(exp_sr));
            check(TBL[i][4] ? (TBL[i][5] ? "R7 vec" : "R6 vec") : "R5 vec kept",
                  32'(vec_addr), 32'(exp_vec));
        end

        // R9 write and read back
        @(negedge clk);
        sr_wr_en = 1'b1; sr_wr_data = 8'hA5;
        @(negedge clk);
        sr_wr_en = 1'b0;
        check("R9 write", 32'(sr_rd_data), 32'hA5);

        // R10 write and accept in the same cycle
        irq_req = 8'h40; irq_mask = 1'b0; vec_split = 1'b1;
        sr_wr_en = 1'b1; sr_wr_data = 8'h00; irq_ack = 1'b1;
        @(negedge clk);
        sr_wr_en = 1'b0; irq_ack = 1'b0;
        check("R10 merge", 32'(sr_rd_data), 32'h0C);
        check("R7 vec level6", 32'(vec_addr), 32'hFFFA);

        // R4 other bits preserved
        sr_wr_en = 1'b1; sr_wr_data = 8'hFF;
        @(negedge clk);
        sr_wr_en = 1'b0;
        irq_req = 8'h06; irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check("R4 keep other bits", 32'(sr_rd_data), 32'hF3);
        check("R7 vec level1", 32'(vec_addr), 32'hFFF0);

        // R8 BRK in per-level mode
        irq_req = 8'h00; brk_ack = 1'b1;
        @(negedge clk);
        brk_ack = 1'b0;
        check("R8 brk vec", 32'(vec_addr), 32'hFFFE);
        check("R8 brk sr", 32'(sr_rd_data), 32'hF3);

        // R8 BRK with a same-cycle acceptance: acceptance wins
        irq_req = 8'h80; brk_ack = 1'b1; irq_ack = 1'b1;
        @(negedge clk);
        brk_ack = 1'b0; irq_ack = 1'b0;
        check("R8 accept wins vec", 32'(vec_addr), 32'hFFFC);
        check("R4 level7", 32'(sr_rd_data), 32'hFF);

        // R11 hold while requests, mask and BRK move without ack or write
        irq_req = 8'h01; irq_mask = 1'b1;
        @(negedge clk);
        irq_mask = 1'b0; irq_req = 8'h10; brk_ack = 1'b1;
        @(negedge clk);
        brk_ack = 1'b0;
        @(negedge clk);
        check("R11 sr hold", 32'(sr_rd_data), 32'hFF);

        // R3 masked level stays visible, ack ignored
        irq_req = 8'h08; irq_mask = 1'b1; #1;
        check("R3 masked level visible", 32'(req_level), 32'd3);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check("R5 masked ack sr", 32'(sr_rd_data), 32'hFF);
        check("R5 masked ack vec", 32'(vec_addr), 32'hFFFE);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule